// File: doc/BRIEF.md
# Timestamp Capture Bank for Precision Time Frames

This block holds hardware timestamps for precision-time event frames until software collects them. It watches a free-running 64-bit nanosecond time value supplied from outside. When an external frame parser flags a received event frame, or the transmit path flags an outgoing one, the block copies the current time into a holding slot. There are four receive slots and one transmit slot. Each slot carries a latched-valid flag that stays set until software reads the upper 32-bit half of that slot. Reading the upper half frees the slot for the next capture.

On the receive side, every parser strobe produces a one-cycle tag. The tag says whether a timestamp was taken and which slot holds it, so the index can be written into the frame's receive descriptor. A received frame is captured only if the global enable is set, the frame's protocol version matches the configured version, and, for UDP-encapsulated frames, UDP capture is allowed. When all receive slots are occupied, frames are still tagged, but as having no timestamp.

The transmit slot can drive an interrupt when its enable bit is set. A transmit capture request that arrives while the transmit slot is still occupied is dropped, and a sticky overrun flag is raised.

Top module: `ptp_stamp_bank`

## Requirements
- R1: After reset, all receive slots and the transmit slot are empty. After reset, tx_ovr, tx_irq, rx_tag_vld and rd_data are zero, the global enable is off and the version filter is 0 (none).
- R2: A receive strobe is qualified only when all of the following hold:
  - the global enable is set;
  - the configured version filt_ver is 1 or 2 (0 and 3 accept nothing);
  - rx_evt_ver equals filt_ver;
  - rx_evt_udp is low, or the UDP enable filt_udp is set.
- R3: A qualified receive strobe captures into the lowest-numbered free slot n. stat_rx bit n is 1 exactly while receive slot n holds a latched stamp.
- R4: A slot stores time_now as sampled at its capture edge. rd_sel values 0 to 3 select receive slot 0 to 3, and 4 selects the transmit slot. rd_hi=0 returns bits 31:0 and rd_hi=1 returns bits 63:32. The word appears on rd_data one cycle after rd_en and holds until the next read. Any other rd_sel reads zero.
- R5: A read with rd_hi=1 clears the valid flag of the selected slot. A read with rd_hi=0 leaves the flag unchanged.
- R6: When all four receive slots are latched, a qualified receive strobe captures nothing and its tag reports no timestamp.
- R7: Every rx_evt produces, one cycle later, rx_tag_vld=1. With it come rx_tag_hit, which is 1 if a stamp was taken, and rx_tag_idx, which gives the slot used when rx_tag_hit is 1.
- R8: If a slot is released by an upper-half read in the same cycle as a capture request, the release is applied first. The freed slot can then take the new capture, and the stamp is kept.
- R9: A tx_evt with the global enable set captures into the transmit slot when that slot is free or is being released in the same cycle. stat_tx shows that the transmit slot is occupied.
- R10: A tx_evt with the enable set, while the transmit slot is latched and not being released, is dropped and sets tx_ovr. tx_ovr clears on an upper-half read of the transmit slot.
- R11: tx_irq is 1 exactly while the transmit slot is latched and the interrupt enable filt_txie is set.
- R12: While the global enable is off, capture strobes in both directions change no slot. A filt_wr write replaces the version, UDP and interrupt-enable fields but leaves the global enable unchanged. The global enable is written only through en_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current nanosecond time |
| en_wr | input | 1 | Write strobe for the global enable |
| en_val | input | 1 | New global enable value |
| filt_wr | input | 1 | Write strobe for the filter fields |
| filt_ver | input | 2 | Accepted version: 0 none, 1 v1, 2 v2, 3 none |
| filt_udp | input | 1 | Allow UDP-encapsulated event frames |
| filt_txie | input | 1 | Transmit-capture interrupt enable |
| rx_evt | input | 1 | Parser strobe: received event frame |
| rx_evt_ver | input | 2 | Protocol version of the received frame |
| rx_evt_udp | input | 1 | Received frame is UDP-encapsulated |
| tx_evt | input | 1 | Transmit event frame strobe |
| rd_en | input | 1 | Read request |
| rd_sel | input | 3 | Slot select: 0-3 receive, 4 transmit |
| rd_hi | input | 1 | 1 selects the upper half and releases the slot |
| rd_data | output | 32 | Read word, one cycle after rd_en |
| stat_rx | output | 4 | Receive slot valid flags |
| stat_tx | output | 1 | Transmit slot valid flag |
| tx_ovr | output | 1 | Sticky transmit overrun |
| tx_irq | output | 1 | Transmit timestamp interrupt |
| rx_tag_vld | output | 1 | Receive tag strobe |
| rx_tag_hit | output | 1 | Receive tag: stamp taken |
| rx_tag_idx | output | 2 | Receive tag: slot index |

## Verification
Several directed sequences are applied first:
- filling the bank in order shows that allocation picks the lowest free slot;
- freeing a middle slot and then capturing again shows that the hole is reused;
- a strobe on a full bank separates a tag with no stamp from a lost tag;
- an upper-half read in the same cycle as a strobe shows that release is applied before capture.

Back-to-back transmit strobes separate the overrun path from a normal capture. Strobes with the enable off, and filter writes with the enable on, show that gating and enable retention work. A long random phase then mixes versions, UDP flags, reads of both halves and configuration changes, to exercise allocation under arbitrary occupancy patterns.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;
  typedef enum logic [1:0] {
    VER_NONE = 2'd0,
    VER_ONE  = 2'd1,
    VER_TWO  = 2'd2,
    VER_RSVD = 2'd3
  } ver_sel_e;

  function automatic logic ver_accepts(input logic [1:0] cfg, input logic [1:0] frm);
    return ((cfg == VER_ONE) || (cfg == VER_TWO)) && (cfg == frm);
  endfunction
endpackage

// File: rtl/ptp_rx_qual.sv
module ptp_rx_qual
  import ptp_stamp_pkg::*;
(
  input  logic       run,
  input  logic [1:0] cfg_ver,
  input  logic       cfg_udp,
  input  logic       evt,
  input  logic [1:0] evt_ver,
  input  logic       evt_udp,
  output logic       take
);
  logic ver_ok;
  logic udp_ok;

  always_comb begin
    ver_ok = ver_accepts(cfg_ver, evt_ver);
    udp_ok = !evt_udp || cfg_udp;
    take   = evt && run && ver_ok && udp_ok;
  end
endmodule

// File: rtl/ptp_slot_alloc.sv
module ptp_slot_alloc #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [N-1:0]  rel,
  input  logic          req,
  output logic [N-1:0]  cap,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [N-1:0] free_m;
  logic [N:0]   seen;

  assign free_m  = ~vld | rel;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_pick
    assign seen[g+1] = seen[g] | free_m[g];
    assign cap[g]    = req & free_m[g] & ~seen[g];
  end

  assign hit = req & seen[N];

  always_comb begin
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (free_m[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/ptp_stamp_slot.sv
module ptp_stamp_slot #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          rel,
  input  logic [TW-1:0] din,
  output logic          vld,
  output logic [TW-1:0] q
);
  logic vld_nx;

  always_comb begin
    vld_nx = vld;
    if (rel) vld_nx = 1'b0;
    if (cap) vld_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (cap) q <= din;
  end
endmodule

// File: rtl/ptp_stamp_bank.sv
module ptp_stamp_bank #(
  parameter int WW  = 32,
  parameter int NRX = 4,
  localparam int TW = 2 * WW,
  localparam int IW = (NRX > 1) ? $clog2(NRX) : 1,
  localparam int SW = $clog2(NRX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          en_wr,
  input  logic          en_val,
  input  logic          filt_wr,
  input  logic [1:0]    filt_ver,
  input  logic          filt_udp,
  input  logic          filt_txie,
  input  logic          rx_evt,
  input  logic [1:0]    rx_evt_ver,
  input  logic          rx_evt_udp,
  input  logic          tx_evt,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_sel,
  input  logic          rd_hi,
  output logic [WW-1:0] rd_data,
  output logic [NRX-1:0] stat_rx,
  output logic          stat_tx,
  output logic          tx_ovr,
  output logic          tx_irq,
  output logic          rx_tag_vld,
  output logic          rx_tag_hit,
  output logic [IW-1:0] rx_tag_idx
);
  localparam logic [SW-1:0] TX_SEL = SW'(NRX);

  // configuration
  logic       run_q, run_nx;
  logic [1:0] ver_q, ver_nx;
  logic       udp_q, udp_nx;
  logic       ie_q, ie_nx;

  always_comb begin
    run_nx = run_q;
    ver_nx = ver_q;
    udp_nx = udp_q;
    ie_nx  = ie_q;
    if (en_wr) run_nx = en_val;
    if (filt_wr) begin
      ver_nx = filt_ver;
      udp_nx = filt_udp;
      ie_nx  = filt_txie;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ver_q <= 2'd0;
      udp_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      run_q <= run_nx;
      ver_q <= ver_nx;
      udp_q <= udp_nx;
      ie_q  <= ie_nx;
    end
  end

  // release decode
  logic           rel_hi;
  logic [NRX-1:0] rx_rel;
  logic           tx_rel;

  assign rel_hi = rd_en & rd_hi;
  for (genvar g = 0; g < NRX; g++) begin : g_rel
    assign rx_rel[g] = rel_hi & (rd_sel == SW'(g));
  end
  assign tx_rel = rel_hi & (rd_sel == TX_SEL);

  // receive path
  logic           rx_take;
  logic [NRX-1:0] rx_cap;
  logic           rx_hit;
  logic [IW-1:0]  rx_idx;
  logic [TW-1:0]  rx_q [NRX];

  ptp_rx_qual u_qual (
    .run     (run_q),
    .cfg_ver (ver_q),
    .cfg_udp (udp_q),
    .evt     (rx_evt),
    .evt_ver (rx_evt_ver),
    .evt_udp (rx_evt_udp),
    .take    (rx_take)
  );

  ptp_slot_alloc #(.N(NRX)) u_alloc (
    .vld (stat_rx),
    .rel (rx_rel),
    .req (rx_take),
    .cap (rx_cap),
    .hit (rx_hit),
    .idx (rx_idx)
  );

  for (genvar g = 0; g < NRX; g++) begin : g_rx
    ptp_stamp_slot #(.TW(TW)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (rx_cap[g]),
      .rel   (rx_rel[g]),
      .din   (time_now),
      .vld   (stat_rx[g]),
      .q     (rx_q[g])
    );
  end

  // transmit path
  logic          tx_cap;
  logic          tx_drop;
  logic [TW-1:0] tx_q;
  logic          ovr_nx;

  assign tx_cap  = tx_evt & run_q & (~stat_tx | tx_rel);
  assign tx_drop = tx_evt & run_q & stat_tx & ~tx_rel;

  ptp_stamp_slot #(.TW(TW)) u_tx_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (tx_cap),
    .rel   (tx_rel),
    .din   (time_now),
    .vld   (stat_tx),
    .q     (tx_q)
  );

  always_comb begin
    ovr_nx = tx_ovr;
    if (tx_rel)  ovr_nx = 1'b0;
    if (tx_drop) ovr_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_ovr <= 1'b0;
    else        tx_ovr <= ovr_nx;
  end

  assign tx_irq = stat_tx & ie_q;

  // read port
  logic [TW-1:0] sel_stamp;
  logic [WW-1:0] sel_word;

  always_comb begin
    sel_stamp = '0;
    for (int k = 0; k < NRX; k++) begin
      if (rd_sel == SW'(k)) sel_stamp = rx_q[k];
    end
    if (rd_sel == TX_SEL) sel_stamp = tx_q;
    sel_word = rd_hi ? sel_stamp[TW-1:WW] : sel_stamp[WW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= sel_word;
  end

  // receive tag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_tag_vld <= 1'b0;
      rx_tag_hit <= 1'b0;
      rx_tag_idx <= '0;
    end else begin
      rx_tag_vld <= rx_evt;
      rx_tag_hit <= rx_hit;
      rx_tag_idx <= rx_hit ? rx_idx : '0;
    end
  end
endmodule

// File: rtl/ptp_stamp_bank_chk.sv
module ptp_stamp_bank_chk #(
  parameter int NRX = 4,
  localparam int IW = (NRX > 1) ? $clog2(NRX) : 1,
  localparam int SW = $clog2(NRX + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_evt,
  input logic           tx_evt,
  input logic           rd_en,
  input logic           rd_hi,
  input logic [SW-1:0]  rd_sel,
  input logic [NRX-1:0] stat_rx,
  input logic           stat_tx,
  input logic           tx_ovr,
  input logic           tx_irq,
  input logic           rx_tag_vld,
  input logic           rx_tag_hit,
  input logic [IW-1:0]  rx_tag_idx,
  input logic           run_q,
  input logic           ie_q,
  input logic [NRX-1:0] rx_cap
);
  logic rx_rel_any;
  logic tx_rel_now;

  assign rx_rel_any = rd_en && rd_hi && (rd_sel < SW'(NRX));
  assign tx_rel_now = rd_en && rd_hi && (rd_sel == SW'(NRX));

  AST_CAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_cap)); // R3

  AST_TAG_SLOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tag_vld && rx_tag_hit) |-> stat_rx[rx_tag_idx]); // R7

  AST_TAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> rx_tag_vld); // R7

  AST_FULL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_evt && (&stat_rx) && !rx_rel_any) |=> !rx_tag_hit); // R6

  AST_HI_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rel_any && !rx_evt) |=> !stat_rx[$past(rd_sel[IW-1:0])]); // R5

  AST_TX_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tx_evt && stat_tx && !tx_rel_now) |=> tx_ovr); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !tx_irq); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !rd_en) |=> ($stable(stat_rx) && $stable(stat_tx))); // R12
endmodule

bind ptp_stamp_bank ptp_stamp_bank_chk #(.NRX(NRX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_evt     (rx_evt),
  .tx_evt     (tx_evt),
  .rd_en      (rd_en),
  .rd_hi      (rd_hi),
  .rd_sel     (rd_sel),
  .stat_rx    (stat_rx),
  .stat_tx    (stat_tx),
  .tx_ovr     (tx_ovr),
  .tx_irq     (tx_irq),
  .rx_tag_vld (rx_tag_vld),
  .rx_tag_hit (rx_tag_hit),
  .rx_tag_idx (rx_tag_idx),
  .run_q      (run_q),
  .ie_q       (ie_q),
  .rx_cap     (rx_cap)
);

// File: tb/ptp_stamp_bank_bench.sv
`timescale 1ns/1ps
module ptp_stamp_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        en_wr = 0, en_val = 0, filt_wr = 0, filt_udp = 0, filt_txie = 0;
  logic [1:0]  filt_ver = 0, rx_evt_ver = 0;
  logic        rx_evt = 0, rx_evt_udp = 0, tx_evt = 0, rd_en = 0, rd_hi = 0;
  logic [2:0]  rd_sel = 0;
  logic [31:0] rd_data;
  logic [3:0]  stat_rx;
  logic        stat_tx, tx_ovr, tx_irq, rx_tag_vld, rx_tag_hit;
  logic [1:0]  rx_tag_idx;

  always #10 clk = ~clk;

  ptp_stamp_bank u_ptp_stamp_bank (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  bit        m_vld [4];
  bit [63:0] m_ts  [4];
  bit        m_txv, m_ovr, m_run, m_udp, m_ie;
  bit [63:0] m_txts;
  bit [1:0]  m_ver;
  bit [31:0] m_rd;
  bit        m_tv, m_th;
  bit [1:0]  m_ti;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit qual_ok();
    return m_run && (m_ver == 2'd1 || m_ver == 2'd2) && (rx_evt_ver == m_ver)
           && (!rx_evt_udp || m_udp);
  endfunction

  function automatic bit [3:0] m_stat();
    bit [3:0] s;
    for (int k = 0; k < 4; k++) s[k] = m_vld[k];
    return s;
  endfunction

  task automatic model_edge();
    bit relhi;
    bit [63:0] w;
    bit found;
    bit q;
    relhi = rd_en && rd_hi;
    if (rd_en) begin
      w = (rd_sel < 4) ? m_ts[rd_sel[1:0]] : (rd_sel == 4 ? m_txts : 64'd0);
      m_rd = rd_hi ? w[63:32] : w[31:0];
    end
    q = rx_evt && qual_ok();
    if (relhi && rd_sel < 4) m_vld[rd_sel[1:0]] = 0;
    m_tv = rx_evt; m_th = 0; m_ti = 0; found = 0;
    if (q) begin
      for (int k = 0; k < 4; k++) if (!found && !m_vld[k]) begin
        found = 1; m_vld[k] = 1; m_ts[k] = time_now; m_th = 1; m_ti = 2'(k);
      end
    end
    if (relhi && rd_sel == 4) begin m_txv = 0; m_ovr = 0; end
    if (tx_evt && m_run) begin
      if (!m_txv) begin m_txv = 1; m_txts = time_now; end
      else m_ovr = 1;
    end
    if (en_wr) m_run = en_val;
    if (filt_wr) begin m_ver = filt_ver; m_udp = filt_udp; m_ie = filt_txie; end
  endtask

  task automatic compare_all();
    chk("R3 R5 R6 stat_rx", stat_rx, m_stat());
    chk("R9 stat_tx", stat_tx, m_txv);
    chk("R10 tx_ovr", tx_ovr, m_ovr);
    chk("R11 tx_irq", tx_irq, m_txv && m_ie);
    chk("R4 rd_data", rd_data, m_rd);
    chk("R7 rx_tag_vld", rx_tag_vld, m_tv);
    chk("R2 R7 rx_tag_hit", rx_tag_hit, m_th);
    if (m_th) chk("R3 R7 rx_tag_idx", rx_tag_idx, m_ti);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
    en_wr = 0; filt_wr = 0; rx_evt = 0; tx_evt = 0; rd_en = 0;
    time_now = {$urandom, $urandom};
  endtask

  task automatic rx(input bit [1:0] v, input bit u);
    rx_evt = 1; rx_evt_ver = v; rx_evt_udp = u; tick();
  endtask

  task automatic rd(input bit [2:0] s, input bit h);
    rd_en = 1; rd_sel = s; rd_hi = h; tick();
  endtask

  task automatic cfg(input bit [1:0] v, input bit u, input bit ie);
    filt_wr = 1; filt_ver = v; filt_udp = u; filt_txie = ie; tick();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bit [63:0] saved;
    void'($urandom(32'd4242));
    for (int k = 0; k < 4; k++) begin m_vld[k] = 0; m_ts[k] = 0; end
    m_txv = 0; m_ovr = 0; m_run = 0; m_udp = 0; m_ie = 0; m_txts = 0;
    m_ver = 0; m_rd = 0; m_tv = 0; m_th = 0; m_ti = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 stat_rx", stat_rx, 0);
    chk("R1 stat_tx", stat_tx, 0);
    chk("R1 tx_ovr", tx_ovr, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 rx_tag_vld", rx_tag_vld, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    tick();

    // R12: disabled, strobes ignored
    cfg(2'd2, 1, 1);
    rx(2'd2, 0);
    chk("R12 disabled rx", stat_rx, 0);
    tx_evt = 1; tick();
    chk("R12 disabled tx", stat_tx, 0);
    en_wr = 1; en_val = 1; tick();
    // R12: filter write keeps enable
    cfg(2'd1, 0, 1);
    rx(2'd1, 0);
    chk("R12 enable kept", stat_rx, 4'b0001);
    // R2: version mismatch and udp gating
    rx(2'd2, 0);
    chk("R2 wrong version", rx_tag_hit, 0);
    rx(2'd1, 1);
    chk("R2 udp blocked", rx_tag_hit, 0);
    cfg(2'd1, 1, 1);
    saved = time_now;
    rx(2'd1, 1);
    chk("R2 udp allowed", rx_tag_idx, 1);
    // R4: stamp readback
    rd(3'd1, 0);
    chk("R4 low word", rd_data, saved[31:0]);
    chk("R5 low read keeps", stat_rx[1], 1);
    rd(3'd1, 1);
    chk("R4 high word", rd_data, saved[63:32]);
    chk("R5 high read frees", stat_rx[1], 0);
    // R3: hole reuse, then fill
    rx(2'd1, 0);
    chk("R3 hole reused", rx_tag_idx, 1);
    rx(2'd1, 0); rx(2'd1, 0);
    chk("R6 bank full", stat_rx, 4'hF);
    rx(2'd1, 0);
    chk("R6 full no stamp", rx_tag_hit, 0);
    chk("R6 full tag still", rx_tag_vld, 1);
    // R8: release and capture same cycle
    rd_en = 1; rd_sel = 3'd2; rd_hi = 1; rx_evt = 1; rx_evt_ver = 2'd1; rx_evt_udp = 0;
    tick();
    chk("R8 same-cycle hit", rx_tag_hit, 1);
    chk("R8 same-cycle idx", rx_tag_idx, 2);
    chk("R8 slot kept", stat_rx, 4'hF);
    // R9 R10 R11: transmit
    tx_evt = 1; tick();
    chk("R9 tx captured", stat_tx, 1);
    chk("R11 irq on", tx_irq, 1);
    tx_evt = 1; tick();
    chk("R10 overrun", tx_ovr, 1);
    cfg(2'd1, 1, 0);
    chk("R11 irq masked", tx_irq, 0);
    rd(3'd4, 1);
    chk("R10 ovr cleared", tx_ovr, 0);
    chk("R9 tx freed", stat_tx, 0);
    rd(3'd6, 0);
    chk("R4 unused select", rd_data, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) begin en_wr = 1; en_val = ($urandom_range(0, 9) != 0); end
      if (r >= 3 && r < 6) begin
        filt_wr = 1; filt_ver = 2'($urandom); filt_udp = 1'($urandom); filt_txie = 1'($urandom);
      end
      rx_evt = ($urandom_range(0, 2) == 0);
      rx_evt_ver = ($urandom_range(0, 5) == 0) ? 2'($urandom) : m_ver;
      rx_evt_udp = 1'($urandom);
      tx_evt = ($urandom_range(0, 5) == 0);
      rd_en = ($urandom_range(0, 2) == 0);
      rd_sel = 3'($urandom_range(0, 5));
      rd_hi = 1'($urandom);
      tick();
    end
    done = 1;
    summary();
    $finish;
  end
endmodule